// File: doc/BRIEF.md
# Masked BCD Alarm Matcher

This block watches the running time and date of a real-time clock and raises an alarm when the time reaches a programmed value. It holds one alarm byte for each of the seconds, minutes, hours and date fields. Each byte carries a two-digit BCD value and a mask bit. A field whose mask bit is clear must equal the current time field. A field whose mask bit is set is left out of the comparison. Only the unmasked fields decide whether the alarm fires.

The comparison is made once per seconds tick. When every unmasked field matches on a tick, the block emits a one-cycle match pulse. It also sets a sticky alarm flag, which stays set until software reads the flags register. The alarm bytes can be written only while a write-enable input is held high. The block does not contain the timekeeping counters, the calendar rollover or the interrupt routing; it takes the current time from outside.

Top module: `alarm_matcher`

## Requirements
- R1: After a synchronous active-low reset, `alarm_flag` and `match_pulse` are 0 and every alarm byte is 0x00, which means all fields are unmasked with value 00. A tick with the current time at all zeros therefore matches.
- R2: The layout of an alarm byte is: bit 7 is the mask, bits 6:4 hold the BCD tens digit and bits 3:0 hold the BCD units digit. Bits 6:0 are compared against the 7-bit current field, so a difference in the tens digit alone prevents a match.
- R3: On a cycle with `sec_tick` high and every unmasked field equal, `match_pulse` is 1 and `alarm_flag` is 1 one cycle later.
- R4: A field whose mask bit is 1 does not affect the result, whatever its current value.
- R5: No match is evaluated without `sec_tick`. Equal fields without a tick produce no pulse and leave the flag unchanged.
- R6: With all four fields masked, every seconds tick produces a match pulse.
- R7: `alarm_flag` stays set until `flags_rd` is sampled high, and it reads 0 on the following cycle.
- R8: If `flags_rd` and a new match occur in the same cycle, the flag stays 1.
- R9: A write with `reg_wr` high while `wr_en` is low leaves the alarm byte unchanged. `reg_addr` selects the byte: 0 for seconds, 1 for minutes, 2 for hours, 3 for date.
- R10: `match_pulse` lasts one cycle for each matching tick and is 0 on the cycle after a cycle without a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking a new second |
| cur_time | input | 28 | Current BCD time, 7 bits per field: [6:0] seconds, [13:7] minutes, [20:14] hours, [27:21] date |
| wr_en | input | 1 | Alarm register write enable |
| reg_wr | input | 1 | Alarm register write strobe |
| reg_addr | input | 2 | Alarm field select (0 sec, 1 min, 2 hour, 3 date) |
| reg_wdata | input | 8 | Alarm byte to write |
| flags_rd | input | 1 | Flags register read strobe, clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| match_pulse | output | 1 | One-cycle pulse on each matching tick |

## Verification
The bench first drives a time that misses by one second, then the exact alarm time. This shows that the comparison needs every unmasked field to be equal. A time that differs only in the seconds tens digit shows that the upper BCD bits are compared. The same time with the seconds field masked shows that a masked field is left out. An exact match held without a tick separates matching from tick-driven evaluation. An all-masked setup shows the alarm firing on every tick. A read that arrives together with a match, and then a read alone, separate the two outcomes of the flag clear. A write attempted with the enable low, followed by a match against the old value, shows that the write gate holds.

// File: rtl/alm_pkg.sv
// Package: shared alarm byte layout and widths for the alarm matcher.
// Assumes the time source presents 7-bit BCD fields (tens 6:4, units 3:0).
package alm_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned VAL_W  = 7;

    typedef struct packed {
        logic       mask;   // 1 = field ignored
        logic [2:0] tens;
        logic [3:0] units;
    } alm_field_t;
endpackage

// File: rtl/alm_regs.sv
// Module: alarm byte register file, one byte per time field.
// Assumes writes are gated by wr_en; addresses beyond N_FIELDS are dropped.
module alm_regs #(
    parameter int unsigned N_FIELDS = 4,
    parameter int unsigned ADDR_W   = $clog2(N_FIELDS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic                                  reg_wr,
    input  logic [ADDR_W-1:0]                     reg_addr,
    input  logic [alm_pkg::BYTE_W-1:0]            reg_wdata,
    output alm_pkg::alm_field_t [N_FIELDS-1:0]    alarm_q
);
    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_byte
        // Purpose: hold one alarm byte, load it on an enabled write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_q[gi] <= '0;
            else if (wr_en && reg_wr && (reg_addr == ADDR_W'(gi)))
                alarm_q[gi] <= alm_pkg::alm_field_t'(reg_wdata);
        end
    end

    // R9: bytes never move while the write enable is low
    p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_en) |=> $stable(alarm_q));
endmodule

// File: rtl/alm_field_cmp.sv
// Module: single-field comparator; a masked field always reports a match.
// Assumes the current value uses the same 7-bit BCD layout as the alarm byte.
module alm_field_cmp (
    input  alm_pkg::alm_field_t         alarm,
    input  logic [alm_pkg::VAL_W-1:0]   cur,
    output logic                        ok
);
    // Purpose: field passes when masked or when tens and units both agree.
    always_comb begin
        ok = alarm.mask || ({alarm.tens, alarm.units} == cur);
    end
endmodule

// File: rtl/alm_flag.sv
// Module: sticky alarm flag and one-cycle match pulse.
// Assumes hit is already qualified by the seconds tick.
module alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flags_rd,
    output logic alarm_flag,
    output logic match_pulse
);
    // Purpose: set the flag on a hit (a hit wins over a read), clear it on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_flag <= 1'b0;
        else if (hit)
            alarm_flag <= 1'b1;
        else if (flags_rd)
            alarm_flag <= 1'b0;
    end

    // Purpose: register the hit as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_pulse <= 1'b0;
        else
            match_pulse <= hit;
    end

    // R8: a hit leaves both the flag and the pulse set, even with a read
    p_hit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hit) |=> (alarm_flag && match_pulse));
    // R7: a read without a hit clears the flag
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && flags_rd && !hit) |=> !alarm_flag);
    // R7: without a read the flag stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && alarm_flag && !flags_rd) |=> alarm_flag);
    // R10: no pulse after a cycle without a hit
    p_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !hit) |=> !match_pulse);
endmodule

// File: rtl/alarm_matcher.sv
// Module: top of the masked BCD alarm matcher.
// Assumes cur_time packs N_FIELDS 7-bit BCD fields, with field 0 (seconds) in the low bits.
module alarm_matcher #(
    parameter int unsigned N_FIELDS = 4,
    localparam int unsigned ADDR_W  = $clog2(N_FIELDS),
    localparam int unsigned TIME_W  = N_FIELDS * alm_pkg::VAL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sec_tick,
    input  logic [TIME_W-1:0]          cur_time,
    input  logic                       wr_en,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [alm_pkg::BYTE_W-1:0] reg_wdata,
    input  logic                       flags_rd,
    output logic                       alarm_flag,
    output logic                       match_pulse
);
    alm_pkg::alm_field_t [N_FIELDS-1:0] alarm_q;
    logic [N_FIELDS-1:0]                field_ok;
    logic [N_FIELDS-1:0]                field_mask;
    logic                               hit;

    alm_regs #(.N_FIELDS(N_FIELDS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .alarm_q   (alarm_q)
    );

    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_cmp
        alm_field_cmp u_cmp (
            .alarm (alarm_q[gi]),
            .cur   (cur_time[gi*alm_pkg::VAL_W +: alm_pkg::VAL_W]),
            .ok    (field_ok[gi])
        );
        assign field_mask[gi] = alarm_q[gi].mask;
    end

    // Purpose: evaluate the match only on a seconds tick.
    always_comb begin
        hit = sec_tick && (&field_ok);
    end

    alm_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .flags_rd    (flags_rd),
        .alarm_flag  (alarm_flag),
        .match_pulse (match_pulse)
    );

    // R1: outputs are clear after a reset cycle
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!alarm_flag && !match_pulse));
    // R5: no tick, no pulse
    p_tick_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !sec_tick) |=> !match_pulse);
    // R6: all fields masked means every tick matches
    p_all_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sec_tick && (&field_mask)) |=> match_pulse);
    // R3: a pulse always comes with the flag set
    p_pulse_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> alarm_flag);
endmodule

// File: tb/alarm_matcher_bench.sv
module alarm_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [27:0] cur_time = '0;
    logic        wr_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        flags_rd = 1'b0;
    logic        alarm_flag;
    logic        match_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alarm_matcher u_alarm_matcher (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_time(cur_time),
        .wr_en(wr_en), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .flags_rd(flags_rd), .alarm_flag(alarm_flag), .match_pulse(match_pulse)
    );

    function automatic logic [27:0] tm(input logic [6:0] s, input logic [6:0] m,
                                       input logic [6:0] h, input logic [6:0] d);
        return {d, h, m, s};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic en);
        wr_en = en; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; wr_en = 1'b0;
    endtask

    // one tick cycle with the given time; checks the outputs one edge later
    task automatic tick(input logic [27:0] t, input bit exp_p, input bit exp_f, input string req);
        cur_time = t; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        check(match_pulse == exp_p, req, match_pulse, exp_p);
        check(alarm_flag == exp_f, req, alarm_flag, exp_f);
    endtask

    task automatic rd_flags(input bit exp_f, input string req);
        flags_rd = 1'b1;
        @(negedge clk);
        flags_rd = 1'b0;
        check(alarm_flag == exp_f, req, alarm_flag, exp_f);
    endtask

    task automatic t_reset;
        check(alarm_flag == 1'b0, "R1", alarm_flag, 0);
        check(match_pulse == 1'b0, "R1", match_pulse, 0);
        tick(tm(0, 0, 0, 0), 1'b1, 1'b1, "R1");
        rd_flags(1'b0, "R7");
    endtask

    task automatic t_exact;
        wr(0, 8'h45, 1'b1); wr(1, 8'h30, 1'b1); wr(2, 8'h12, 1'b1); wr(3, 8'h15, 1'b1);
        tick(tm(7'h44, 7'h30, 7'h12, 7'h15), 1'b0, 1'b0, "R3");
        tick(tm(7'h45, 7'h30, 7'h12, 7'h15), 1'b1, 1'b1, "R3");
        @(negedge clk);
        check(match_pulse == 1'b0, "R10", match_pulse, 0);
        check(alarm_flag == 1'b1, "R7", alarm_flag, 1);
        rd_flags(1'b0, "R7");
    endtask

    task automatic t_no_tick;
        cur_time = tm(7'h45, 7'h30, 7'h12, 7'h15);
        repeat (3) @(negedge clk);
        check(match_pulse == 1'b0, "R5", match_pulse, 0);
        check(alarm_flag == 1'b0, "R5", alarm_flag, 0);
    endtask

    task automatic t_tens;
        tick(tm(7'h05, 7'h30, 7'h12, 7'h15), 1'b0, 1'b0, "R2");
    endtask

    task automatic t_mask;
        wr(0, 8'hC5, 1'b1);   // mask set, seconds 45
        tick(tm(7'h17, 7'h30, 7'h12, 7'h15), 1'b1, 1'b1, "R4");
        tick(tm(7'h17, 7'h31, 7'h12, 7'h15), 1'b0, 1'b1, "R4");
        rd_flags(1'b0, "R7");
    endtask

    task automatic t_all_masked;
        for (int i = 0; i < 4; i++) wr(2'(i), 8'h80, 1'b1);
        for (int i = 0; i < 3; i++)
            tick(tm(7'(i), 7'h59, 7'h23, 7'h31), 1'b1, 1'b1, "R6");
    endtask

    task automatic t_read_vs_hit;
        // flag is set from the previous task; read together with a match
        cur_time = tm(7'h01, 7'h02, 7'h03, 7'h04); sec_tick = 1'b1; flags_rd = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0; flags_rd = 1'b0;
        check(alarm_flag == 1'b1, "R8", alarm_flag, 1);
        check(match_pulse == 1'b1, "R8", match_pulse, 1);
        rd_flags(1'b0, "R8");
    endtask

    task automatic t_write_gate;
        wr(0, 8'h45, 1'b1); wr(1, 8'h30, 1'b1); wr(2, 8'h12, 1'b1); wr(3, 8'h15, 1'b1);
        wr(0, 8'h10, 1'b0);   // blocked write
        tick(tm(7'h10, 7'h30, 7'h12, 7'h15), 1'b0, 1'b0, "R9");
        tick(tm(7'h45, 7'h30, 7'h12, 7'h15), 1'b1, 1'b1, "R9");
        rd_flags(1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exact();
        t_no_tick();
        t_tens();
        t_mask();
        t_all_masked();
        t_read_vs_hit();
        t_write_gate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule